// File: doc/BRIEF.md
# Round-Key Table Builder for a Five-Bit-Round Block Cipher

This unit turns a user key of 0 to 63 bytes into the expanded subkey table that the cipher's round engine consumes. A start pulse captures the key length and the round count r. The key bytes then arrive one per write strobe. After the final byte, or at once for an empty key, the unit fills a table of 2r+4 32-bit words. It first seeds the table from two fixed constants. It then mixes the key into the table, one step per clock.

The filled table stays in flip-flops. It is read as a combinational memory: the round engine places a word index on `rd_idx` and gets the matching word on `rd_word` in the same cycle. `busy` covers the whole time from the start pulse to the end of expansion. `done` reports a valid table.

Top module: `rc6_keysched`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` pulse while idle captures `key_len` and `rounds`, zeroes the key words and drops `done`. When `key_len` is 0, expansion begins on the next clock. Otherwise the unit waits for `key_len` bytes.
- R3: Key byte number k (counted from 0) is placed in key word k/4 at bits 8*(k%4)+7 down to 8*(k%4). Bytes that are never written read as zero. The key occupies c = max(1, ceil(key_len/4)) words.
- R4: Expansion begins without any further command once the last key byte has been accepted. `key_we` has no effect outside the byte-collection phase.
- R5: Before mixing, table word 0 is set to 0xB7E15163, and each following word is the previous one plus 0x9E3779B9, for t = 2r+4 words.
- R6: Mixing runs 3*max(t, c) steps, starting with X = Y = 0 and i = j = 0. Each step does the following, with i cycling over t and j over c:
  - X = S[i] = rotl(S[i]+X+Y, 3)
  - Y = L[j] = rotl(L[j]+X+Y, (X+Y) mod 32)
- R7: `done` rises exactly 1 + 3*max(t, c) clock edges after the edge that accepts the last key byte, or after the start edge when the key is empty.
- R8: `busy` is high from the edge after an accepted start until `done` rises. The two are never high together. `done` stays high until the next accepted start.
- R9: `rd_word` gives table word `rd_idx` combinationally. Indices at or above the table capacity (66 words by default) read as zero.
- R10: A `start` pulse that arrives while `busy` is high is ignored, along with its `key_len` and `rounds`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new key load |
| key_len | input | KLEN_W (6) | Key length in bytes, sampled with start |
| rounds | input | RND_W (5) | Round count r, sampled with start |
| key_we | input | 1 | Key byte write strobe |
| key_byte | input | 8 | Key byte data |
| rd_idx | input | RND_W+2 (7) | Table read index |
| rd_word | output | 32 | Table word at rd_idx |
| busy | output | 1 | Loading or expanding |
| done | output | 1 | Table valid |

## Verification
The embedded properties assume that `start` is not raised in the same cycle as the final mixing step. They also assume that `rd_idx` changes only when the bench means it to. The stimulus meets both conditions: it raises `start` only while idle, except in deliberate mid-expansion pulses that arrive two cycles into mixing. The shortest run has 12 mixing steps, so those pulses never coincide with the last step. Random key lengths, round counts and key bytes are mixed with directed cases that cover an empty key, a key longer than the table, and the largest table.

// File: rtl/rc6ks_pkg.sv
package rc6ks_pkg;
   localparam logic [31:0] SEED_P = 32'hB7E15163;
   localparam logic [31:0] STEP_Q = 32'h9E3779B9;

   typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_INIT, PH_MIX} phase_t;

   function automatic logic [31:0] rotl32(input logic [31:0] v, input logic [4:0] n);
      logic [63:0] d;
      d = {v, v} << n;
      return d[63:32];
   endfunction
endpackage

// File: rtl/rc6ks_ctrl.sv
module rc6ks_ctrl
   import rc6ks_pkg::*;
#(
   parameter int RND_W  = 5,
   parameter int KLEN_W = 6,
   parameter int IDX_W  = RND_W + 2,
   parameter int LIDX_W = KLEN_W - 2,
   parameter int STEP_W = RND_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KLEN_W-1:0] key_len,
   input  logic [RND_W-1:0]  rounds,
   input  logic              key_we,
   output phase_t            phase,
   output logic [KLEN_W-1:0] byte_idx,
   output logic [IDX_W-1:0]  i_idx,
   output logic [LIDX_W-1:0] j_idx,
   output logic              clear_l,
   output logic              byte_take,
   output logic              busy,
   output logic              done
);
   phase_t            ph_q;
   logic [KLEN_W-1:0] len_q, cnt_q;
   logic [RND_W-1:0]  rnd_q;
   logic [IDX_W-1:0]  i_q, t_last;
   logic [LIDX_W-1:0] j_q, c_last;
   logic [STEP_W-1:0] step_q, t_ext, c_ext, big, n_last;
   logic              done_q;

   always_comb begin
      t_last = IDX_W'({rnd_q, 1'b0}) + IDX_W'(3);
      c_last = (len_q == '0) ? '0 : LIDX_W'((len_q - KLEN_W'(1)) >> 2);
      t_ext  = STEP_W'(t_last) + STEP_W'(1);
      c_ext  = STEP_W'(c_last) + STEP_W'(1);
      big    = (t_ext > c_ext) ? t_ext : c_ext;
      n_last = STEP_W'(3) * big - STEP_W'(1);
   end

   assign clear_l   = (ph_q == PH_IDLE) && start;
   assign byte_take = (ph_q == PH_LOAD) && key_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         len_q  <= '0;
         rnd_q  <= '0;
         cnt_q  <= '0;
         i_q    <= '0;
         j_q    <= '0;
         step_q <= '0;
         done_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               len_q  <= key_len;
               rnd_q  <= rounds;
               cnt_q  <= '0;
               done_q <= 1'b0;
               ph_q   <= (key_len == '0) ? PH_INIT : PH_LOAD;
            end
            PH_LOAD: if (key_we) begin
               cnt_q <= cnt_q + KLEN_W'(1);
               if (cnt_q == len_q - KLEN_W'(1)) ph_q <= PH_INIT;
            end
            PH_INIT: begin
               i_q    <= '0;
               j_q    <= '0;
               step_q <= '0;
               ph_q   <= PH_MIX;
            end
            PH_MIX: begin
               step_q <= step_q + STEP_W'(1);
               i_q    <= (i_q == t_last) ? '0 : i_q + IDX_W'(1);
               j_q    <= (j_q == c_last) ? '0 : j_q + LIDX_W'(1);
               if (step_q == n_last) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase    = ph_q;
   assign byte_idx = cnt_q;
   assign i_idx    = i_q;
   assign j_idx    = j_q;
   assign busy     = (ph_q != PH_IDLE);
   assign done     = done_q;

   // R8: table-valid and working are exclusive
   a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
   // R8: valid flag persists until a new start
   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done);
   // R2: empty key goes straight to expansion
   a_r2_empty_key: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && start && key_len == '0) |=> (busy && ph_q == PH_INIT));
   // R10: settings frozen while working
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && start) |=> ($stable(len_q) && $stable(rnd_q)));
   // R6: step counter stays inside the computed count
   a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MIX) |-> (step_q <= n_last));
endmodule

// File: rtl/rc6ks_mix.sv
module rc6ks_mix
   import rc6ks_pkg::*;
(
   input  logic [31:0] s_in,
   input  logic [31:0] l_in,
   input  logic [31:0] x_in,
   input  logic [31:0] y_in,
   output logic [31:0] x_out,
   output logic [31:0] y_out
);
   logic [31:0] xy_new;
   always_comb begin
      x_out  = rotl32(s_in + x_in + y_in, 5'd3);
      xy_new = x_out + y_in;
      y_out  = rotl32(l_in + xy_new, xy_new[4:0]);
   end
endmodule

// File: rtl/rc6ks_table.sv
module rc6ks_table
   import rc6ks_pkg::*;
#(
   parameter int DEPTH = 66,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [31:0]      wdata,
   input  logic [IDX_W-1:0] ridx_a,
   output logic [31:0]      rdata_a,
   input  logic [IDX_W-1:0] ridx_b,
   output logic [31:0]      rdata_b
);
   logic [31:0] s_q [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_word
      localparam logic [31:0] SEEDV = 32'(SEED_P + STEP_Q * 32'(k));
      always_ff @(posedge clk) begin
         if (!rst_n)                          s_q[k] <= '0;
         else if (seed)                       s_q[k] <= SEEDV;
         else if (we && widx == IDX_W'(k))    s_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata_a = '0;
      rdata_b = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (ridx_a == IDX_W'(k)) rdata_a = s_q[k];
         if (ridx_b == IDX_W'(k)) rdata_b = s_q[k];
      end
   end
endmodule

// File: rtl/rc6_keysched.sv
module rc6_keysched
   import rc6ks_pkg::*;
#(
   parameter int RND_W  = 5,
   parameter int KLEN_W = 6,
   localparam int MAX_T  = 2 * ((1 << RND_W) - 1) + 4,
   localparam int IDX_W  = RND_W + 2,
   localparam int LIDX_W = KLEN_W - 2,
   localparam int MAX_C  = 1 << LIDX_W,
   localparam int STEP_W = RND_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KLEN_W-1:0] key_len,
   input  logic [RND_W-1:0]  rounds,
   input  logic              key_we,
   input  logic [7:0]        key_byte,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [31:0]       rd_word,
   output logic              busy,
   output logic              done
);
   if (RND_W < 1 || RND_W > 6) begin : g_bad_rnd
      $error("rc6_keysched: RND_W out of range");
   end
   if (KLEN_W < 3 || KLEN_W > 8) begin : g_bad_klen
      $error("rc6_keysched: KLEN_W out of range");
   end
   if (MAX_C > MAX_T) begin : g_bad_ratio
      $error("rc6_keysched: key words exceed table depth");
   end

   phase_t            phase;
   logic [KLEN_W-1:0] byte_idx;
   logic [IDX_W-1:0]  i_idx;
   logic [LIDX_W-1:0] j_idx;
   logic              clear_l, byte_take, mixing;
   logic [31:0]       x_q, y_q, x_n, y_n, s_i, l_j;
   logic [31:0]       l_q [MAX_C];

   rc6ks_ctrl #(.RND_W(RND_W), .KLEN_W(KLEN_W), .IDX_W(IDX_W),
                .LIDX_W(LIDX_W), .STEP_W(STEP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len),
      .rounds(rounds), .key_we(key_we), .phase(phase), .byte_idx(byte_idx),
      .i_idx(i_idx), .j_idx(j_idx), .clear_l(clear_l), .byte_take(byte_take),
      .busy(busy), .done(done));

   assign mixing = (phase == PH_MIX);
   assign l_j    = l_q[j_idx];

   rc6ks_mix u_mix (.s_in(s_i), .l_in(l_j), .x_in(x_q), .y_in(y_q),
                    .x_out(x_n), .y_out(y_n));

   rc6ks_table #(.DEPTH(MAX_T), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .seed(phase == PH_INIT), .we(mixing),
      .widx(i_idx), .wdata(x_n), .ridx_a(rd_idx), .rdata_a(rd_word),
      .ridx_b(i_idx), .rdata_b(s_i));

   always_ff @(posedge clk) begin
      if (!rst_n || phase == PH_INIT) begin
         x_q <= '0;
         y_q <= '0;
      end else if (mixing) begin
         x_q <= x_n;
         y_q <= y_n;
      end
   end

   for (genvar w = 0; w < MAX_C; w++) begin : g_key
      always_ff @(posedge clk) begin
         if (!rst_n || clear_l)
            l_q[w] <= '0;
         else if (byte_take && byte_idx[KLEN_W-1:2] == LIDX_W'(w))
            l_q[w][{byte_idx[1:0], 3'b000} +: 8] <= key_byte;
         else if (mixing && j_idx == LIDX_W'(w))
            l_q[w] <= y_n;
      end
   end

   // R9: a finished table does not drift under a steady index
   a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done) && $stable(rd_idx)) |-> $stable(rd_word));
endmodule

// File: tb/rc6_keysched_test.sv
`timescale 1ns/1ps
module rc6_keysched_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [5:0] key_len = '0;
   logic [4:0] rounds = '0;
   logic       key_we = 1'b0;
   logic [7:0] key_byte = '0;
   logic [6:0] rd_idx = '0;
   logic [31:0] rd_word;
   logic       busy, done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [7:0]  kb [64];
   logic [31:0] ref_s [66];
   logic [31:0] ref_l [16];

   always #2 clk = ~clk;

   rc6_keysched uut (.clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len),
      .rounds(rounds), .key_we(key_we), .key_byte(key_byte), .rd_idx(rd_idx),
      .rd_word(rd_word), .busy(busy), .done(done));

   function automatic logic [31:0] rl(input logic [31:0] v, input int n);
      int m = n % 32;
      if (m == 0) return v;
      return (v << m) | (v >> (32 - m));
   endfunction

   function automatic int steps_of(input int len, input int r);
      int t = 2 * r + 4;
      int c = (len == 0) ? 1 : (len + 3) / 4;
      return 3 * ((t > c) ? t : c);
   endfunction

   function automatic void ref_expand(input int len, input int r);
      int t = 2 * r + 4;
      int c = (len == 0) ? 1 : (len + 3) / 4;
      logic [31:0] x = 0, y = 0;
      int i = 0, j = 0;
      for (int k = 0; k < 16; k++) ref_l[k] = 0;
      for (int k = 0; k < len; k++) ref_l[k/4] |= 32'(kb[k]) << (8 * (k % 4));
      ref_s[0] = 32'hB7E15163;
      for (int k = 1; k < t; k++) ref_s[k] = ref_s[k-1] + 32'h9E3779B9;
      for (int n = 0; n < steps_of(len, r); n++) begin
         x = rl(ref_s[i] + x + y, 3);
         ref_s[i] = x;
         y = rl(ref_l[j] + x + y, int'((x + y) & 32'd31));
         ref_l[j] = y;
         i = (i + 1) % t;
         j = (j + 1) % c;
      end
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_table(input int r, input string tag);
      int bad = -1;
      logic [31:0] got = 0;
      for (int k = 0; k < 2 * r + 4; k++) begin
         rd_idx = 7'(k);
         #0.1;
         if (bad < 0 && rd_word !== ref_s[k]) begin
            bad = k;
            got = rd_word;
         end
      end
      chk(bad < 0, tag, "table word", got, (bad < 0) ? 32'd0 : ref_s[bad]);
   endtask

   task automatic run_case(input int len, input int r, input bit noise);
      int cnt = 0;
      ref_expand(len, r);
      @(posedge clk); #1;
      start = 1; key_len = 6'(len); rounds = 5'(r);
      @(posedge clk); #1;
      start = 0;
      for (int k = 0; k < len; k++) begin
         key_we = 1; key_byte = kb[k];
         @(posedge clk); #1;
      end
      key_we = 0;
      // R8 busy right after the accepting edge, done dropped (R2)
      chk(busy === 1'b1 && done === 1'b0, "R8", "busy after load", {busy, done}, 2'b10);
      while (done !== 1'b1 && cnt < 2000) begin
         @(posedge clk); #1;
         cnt++;
         if (noise && cnt == 2) begin   // R10 and R4 disturbance during mixing
            start = 1; key_len = 6'd9; rounds = 5'd2; key_we = 1; key_byte = 8'hA5;
         end
         if (noise && cnt == 3) begin
            start = 0; key_we = 0;
         end
      end
      // R7 latency from last accepted byte
      chk(cnt == steps_of(len, r) + 1, "R7", "latency", cnt, steps_of(len, r) + 1);
      // R3 packing, R5 seeding, R6 mixing
      check_table(r, noise ? "R10" : "R6");
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      chk(busy === 1'b0 && done === 1'b0, "R1", "reset state", {busy, done}, 0);

      // R2 empty key, R6 long table
      run_case(0, 20, 0);
      for (int k = 0; k < 16; k++) kb[k] = 8'(k * 17 + 3);
      run_case(16, 20, 0);
      // R3 key longer than table: c=16 > t=4
      for (int k = 0; k < 63; k++) kb[k] = 8'(8'hF0 ^ k);
      run_case(63, 0, 0);
      // R3 partial last word
      kb[0] = 8'h01; kb[1] = 8'h80; kb[2] = 8'hFF; kb[3] = 8'h7E; kb[4] = 8'hC3;
      run_case(5, 0, 0);
      run_case(1, 31, 0);
      // R10 start ignored during mixing, R4 writes ignored during mixing
      for (int k = 0; k < 12; k++) kb[k] = 8'($urandom);
      run_case(12, 8, 1);

      // R8 done held and R4 writes while idle ignored
      repeat (3) begin
         @(posedge clk); #1;
         key_we = 1; key_byte = 8'h5A;
      end
      @(posedge clk); #1;
      key_we = 0;
      chk(done === 1'b1 && busy === 1'b0, "R8", "done held in idle", {busy, done}, 2'b01);
      check_table(8, "R4");

      // R9 out-of-range indices read zero
      begin
         int bad = -1;
         for (int k = 66; k < 128; k++) begin
            rd_idx = 7'(k);
            #0.1;
            if (bad < 0 && rd_word !== 32'd0) bad = k;
         end
         chk(bad < 0, "R9", "out of range index", bad, 0);
      end
      // R9 combinational read of the last word
      rd_idx = 7'(2 * 8 + 3);
      #0.1;
      chk(rd_word === ref_s[19], "R9", "last word read", rd_word, ref_s[19]);

      // random cases
      for (int n = 0; n < 8; n++) begin
         int len = $urandom_range(0, 63);
         int r = $urandom_range(0, 31);
         for (int k = 0; k < 64; k++) kb[k] = 8'($urandom);
         run_case(len, r, n[0]);
      end

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule